// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters as non-return-to-zero frames on one output line. A hold register takes a character from the write port. The character waits there until the frame shifter is free, and it moves into the shifter at the next bit boundary. Software can therefore load the next character while the current one is still on the wire. When the hold register always has a character waiting, frames follow each other with no idle gap.

The frame shape comes from static configuration inputs. Every frame has a single low start bit, then one to eight data bits sent least significant bit first, then an optional parity bit (even or odd), then one or two high stop bits. The bit period comes from a 16-bit divisor value `baud_sel_i`, counted in cycles of the block clock. Two flags report buffer state: one says the hold register can take a character, and the other says nothing is left to send. An interrupt output mirrors the ready flag and has its own enable. When the transmitter is switched off, any frame in progress is dropped, the hold register is cleared and the line rests high.

Top module: `sertx_top`

## Requirements
- R1: One bit lasts (baud_sel_i+1)*8 clock cycles when baud_sel_i is nonzero, and 16 clock cycles when baud_sel_i is 0.
- R2: Each frame starts with one low start bit. It is followed by len_m1_i+1 data bits, taken from bit 0 of the written character upward.
- R3: Character bits at positions above len_m1_i are not sent, and they do not affect the parity bit.
- R4: With par_en_i=1, one parity bit follows the data. It is the XOR of the sent data bits, inverted when par_odd_i=1. With par_en_i=0, no parity bit is sent.
- R5: A frame ends with one high stop bit, or with two when two_stop_i=1.
- R6: tx_ready_o is 1 while the transmitter is enabled and the hold register is empty. A character waiting in the hold register is taken at the next bit boundary once the shifter is free, which also re-raises tx_ready_o. Back-to-back characters leave no idle time between frames.
- R7: tx_empty_o is 1 only when neither the hold register nor the shifter has data, and the line is then high.
- R8: A write made while tx_ready_o is 0 is dropped. The character already held is still sent unchanged.
- R9: irq_o equals tx_ready_o when irq_en_i=1, and is 0 when irq_en_i=0.
- R10: With tx_en_i=0, the line goes high on the next cycle, any frame in progress is dropped, the hold register is cleared and writes are ignored. After re-enabling, no frame is sent until a new write.
- R11: During reset, txd_o=1, tx_ready_o=0, tx_empty_o=1 and irq_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| baud_sel_i | input | 16 | Bit-rate divisor value |
| len_m1_i | input | 3 | Data bits per frame minus one |
| par_en_i | input | 1 | Send a parity bit |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| two_stop_i | input | 1 | Two stop bits when 1 |
| irq_en_i | input | 1 | Interrupt enable |
| wr_i | input | 1 | Write strobe for the hold register |
| wr_data_i | input | 8 | Character to send |
| tx_ready_o | output | 1 | Hold register can take a character |
| tx_empty_o | output | 1 | Hold register and shifter both idle |
| irq_o | output | 1 | Transmit interrupt |
| txd_o | output | 1 | Serial output, idle high |

## Verification
The assertions are checked on every cycle. They cover these properties: a write is dropped while the hold register is full; the line changes only at bit ticks; two bit ticks are never adjacent; a frame starts only on a tick; disabling forces the line high on the next cycle; the line is high whenever the empty flag is set. The bench scenarios are the only check of the frame contents. Those are the start bit, the data bits in order, the masking of unused bits, both parity senses, one or two stop bits, and the exact bit length for several divisor values. The bench scenarios also show gapless back-to-back frames, a dropped third write, the interrupt gating, and a frame cut off by disabling the transmitter.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LEN_W  = $clog2(DATA_W);
  localparam int unsigned BAUD_W = 16;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } sertx_fmt_t;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned BAUD_W   = 16,
  parameter int unsigned PRE      = 8,
  parameter int unsigned ZERO_DIV = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BAUD_W-1:0] sel_i,
  output logic              tick_o
);
  localparam int unsigned CNT_W = BAUD_W + $clog2(PRE) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    if (sel_i == '0) lim = CNT_W'(ZERO_DIV - 1);
    else             lim = (CNT_W'(sel_i) + CNT_W'(1)) * CNT_W'(PRE) - CNT_W'(1);
  end

  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1: a bit period is never shorter than two cycles
  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R8: a write into a full register leaves the held character alone
  a_r8_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && full_q && wr_i && !take_i) |=> (full_q && data_q == $past(data_q)));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  sertx_fmt_t        fmt_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              have_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic [DATA_W-1:0]  used;
  logic               par_bit;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) used[i] = (i <= int'(len_m1_i)) ? data_i[i] : 1'b0;
    par_bit = (^used) ^ fmt_i.par_odd;
    frame   = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i <= int'(len_m1_i)) frame[i+1] = data_i[i];
    if (fmt_i.par_en) frame[int'(len_m1_i) + 2] = par_bit;
    nbits = CNT_W'(len_m1_i) + CNT_W'(3) + CNT_W'(fmt_i.par_en) + CNT_W'(fmt_i.two_stop);
  end

  // next frame enters on the tick that ends the current one, or any tick when idle
  assign take_o = en_i && tick_i && have_i && (!busy_q || cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (take_o) begin
        busy_q <= 1'b1;
        sh_q   <= frame;
        cnt_q  <= nbits;
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;

  // R6: a frame only starts at a bit boundary
  a_r6_start_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(tick_i));
  // R1: the line holds its level for a whole bit period
  a_r1_steady_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(txd_o));
  // R10: disabling parks the line high
  a_r10_off_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_q && txd_o));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic [BAUD_W-1:0] baud_sel_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              irq_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_ready_o,
  output logic              tx_empty_o,
  output logic              irq_o,
  output logic              txd_o
);
  logic              tick;
  logic              take;
  logic              full;
  logic              busy;
  logic [DATA_W-1:0] held;
  sertx_fmt_t        fmt;

  assign fmt = '{par_en: par_en_i, par_odd: par_odd_i, two_stop: two_stop_i};

  sertx_baud #(.BAUD_W(BAUD_W), .PRE(8), .ZERO_DIV(16)) u_baud (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (tx_en_i),
    .sel_i (baud_sel_i), .tick_o (tick)
  );

  sertx_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (tx_en_i),
    .wr_i (wr_i), .wr_data_i (wr_data_i), .take_i (take),
    .full_o (full), .data_o (held)
  );

  sertx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (tx_en_i), .tick_i (tick),
    .fmt_i (fmt), .len_m1_i (len_m1_i), .have_i (full), .data_i (held),
    .take_o (take), .busy_o (busy), .txd_o (txd_o)
  );

  assign tx_ready_o = tx_en_i && !full;
  assign tx_empty_o = !full && !busy;
  assign irq_o      = irq_en_i && tx_ready_o;

  // R7: nothing pending means the line is marking
  a_r7_empty_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);
endmodule

// File: tb/sertx_top_bench.sv
module sertx_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [15:0] brr = 16'd0;
  logic [2:0] len_m1 = 3'd7;
  logic       pe = 1'b0, po = 1'b0, ts = 1'b0, ie = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'd0;
  logic       rdy, emp, irq, txd;

  always #5 clk = ~clk;

  sertx_top u_sertx_top (
    .clk_i (clk), .rst_ni (rst_n), .tx_en_i (tx_en), .baud_sel_i (brr),
    .len_m1_i (len_m1), .par_en_i (pe), .par_odd_i (po), .two_stop_i (ts),
    .irq_en_i (ie), .wr_i (wr), .wr_data_i (wd),
    .tx_ready_o (rdy), .tx_empty_o (emp), .irq_o (irq), .txd_o (txd)
  );

  typedef struct {
    logic [7:0] d;
    int len;
    bit par_en, par_odd, two_stop;
    int per;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0, seen = 0;
  bit mon_on = 1'b1, done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int per_of(int b);
    return (b == 0) ? 16 : (b + 1) * 8;
  endfunction

  task automatic send(logic [7:0] d);
    item_t it;
    while (!rdy) @(negedge clk);
    wr = 1'b1; wd = d;
    it.d = d; it.len = int'(len_m1) + 1; it.par_en = pe; it.par_odd = po;
    it.two_stop = ts; it.per = per_of(int'(brr));
    q.push_back(it);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0 || !emp) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decode frames at bit midpoints and compare with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && txd === 1'b0) begin
        if (q.size() == 0) begin
          chk(0, "R8", "unexpected frame", 0, 1);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          item_t it;
          logic [7:0] got, msk;
          it = q.pop_front();
          got = '0;
          msk = 8'((16'd1 << it.len) - 16'd1);
          repeat (it.per / 2) @(negedge clk);
          chk(txd == 1'b0, "R2", "start bit", int'(txd), 0);
          for (int i = 0; i < it.len; i++) begin
            repeat (it.per) @(negedge clk);
            got[i] = txd;
          end
          chk(got == (it.d & msk), "R3", "data bits", int'(got), int'(it.d & msk));
          if (it.par_en) begin
            repeat (it.per) @(negedge clk);
            chk(txd == ((^(it.d & msk)) ^ it.par_odd), "R4", "parity bit",
                int'(txd), int'((^(it.d & msk)) ^ it.par_odd));
          end
          repeat (it.per) @(negedge clk);
          chk(txd == 1'b1, "R5", "stop bit 1", int'(txd), 1);
          if (it.two_stop) begin
            repeat (it.per) @(negedge clk);
            chk(txd == 1'b1, "R5", "stop bit 2", int'(txd), 1);
          end
          seen++;
        end
      end
    end
  end

  task automatic measure_bit(int b);
    int n;
    n = 0;
    brr = 16'(b); len_m1 = 3'd7; pe = 1'b0; ts = 1'b0;
    send(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin n++; @(negedge clk); end
    chk(n == per_of(b), "R1", "bit length", n, per_of(b));
    wait_idle();
  endtask

  initial begin
    int s0;
    bit low_seen;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R11", "txd in reset", int'(txd), 1);
    chk(rdy == 1'b0, "R11", "ready in reset", int'(rdy), 0);
    chk(emp == 1'b1, "R11", "empty in reset", int'(emp), 1);
    chk(irq == 1'b0, "R11", "irq in reset", int'(irq), 0);
    rst_n = 1'b1; tx_en = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b1, "R6", "ready after enable", int'(rdy), 1);

    // R1 bit period for several divisors
    measure_bit(0);
    measure_bit(3);
    measure_bit(5);

    // R2 R4 R5 formats
    brr = 16'd2;
    len_m1 = 3'd7; pe = 1'b1; po = 1'b0; ts = 1'b0;
    s0 = seen; send(8'hA7); send(8'h3C); wait_idle();
    po = 1'b1; send(8'hA7); send(8'h00); wait_idle();
    // R3 short words ignore upper bits
    len_m1 = 3'd4; pe = 1'b1; po = 1'b0; send(8'hFF); send(8'hE3); wait_idle();
    len_m1 = 3'd0; pe = 1'b0; send(8'hFE); send(8'h01); wait_idle();
    // R5 two stop bits, back to back
    len_m1 = 3'd6; pe = 1'b1; po = 1'b0; ts = 1'b1;
    send(8'h81); send(8'h7F); send(8'h00); wait_idle();
    chk(seen - s0 == 11, "R2", "frames sent", seen - s0, 11);
    chk(emp == 1'b1 && txd == 1'b1, "R7", "empty after frames", int'(emp), 1);

    // R6 R8 R9 double buffering, dropped write, interrupt
    len_m1 = 3'd7; pe = 1'b0; ts = 1'b0; brr = 16'd1; ie = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R9", "irq when ready", int'(irq), 1);
    s0 = seen;
    send(8'h5A);
    chk(emp == 1'b0, "R7", "not empty after write", int'(emp), 0);
    send(8'hC3);
    chk(rdy == 1'b0, "R6", "ready low with buffer full", int'(rdy), 0);
    chk(irq == 1'b0, "R9", "irq low with buffer full", int'(irq), 0);
    wr = 1'b1; wd = 8'h99; @(negedge clk); wr = 1'b0;
    chk(rdy == 1'b0, "R8", "dropped write keeps ready low", int'(rdy), 0);
    while (!rdy) @(negedge clk);
    chk(emp == 1'b0, "R7", "shifter busy, not empty", int'(emp), 0);
    wait_idle();
    repeat (64) @(negedge clk);
    chk(seen - s0 == 2, "R8", "only two frames", seen - s0, 2);
    ie = 1'b0; @(negedge clk);
    chk(irq == 1'b0, "R9", "irq masked", int'(irq), 0);

    // R10 disable mid-frame
    mon_on = 1'b0;
    wr = 1'b1; wd = 8'hF0; @(negedge clk); wr = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R10", "line high after disable", int'(txd), 1);
    chk(emp == 1'b1, "R10", "empty after disable", int'(emp), 1);
    chk(rdy == 1'b0, "R10", "not ready while off", int'(rdy), 0);
    wr = 1'b1; wd = 8'h00; @(negedge clk); wr = 1'b0;
    tx_en = 1'b1;
    low_seen = 1'b0;
    repeat (200) begin @(negedge clk); if (txd !== 1'b1) low_seen = 1'b1; end
    chk(!low_seen, "R10", "no frame after re-enable", int'(low_seen), 0);
    chk(emp == 1'b1 && rdy == 1'b1, "R10", "idle and ready after re-enable", int'(emp && rdy), 1);
    mon_on = 1'b1;

    // resume normal traffic after abort
    s0 = seen; send(8'h6E); wait_idle();
    chk(seen - s0 == 1, "R6", "frame after abort", seen - s0, 1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule